// File: doc/BRIEF.md
# Single-Dword PCIe Completer Request Handler

This block sits between the receive side of a PCIe endpoint and a simple memory-mapped master bus. It accepts one decoded memory request at a time: a read or write header with its length, address, first byte enables, tag, requester ID and write data. A request of exactly one dword becomes a single 32-bit access on the master bus. The upper address bits are replaced by a programmable window base before the access is issued. Reads end with a request to the transmit-side completion generator, which carries the status, the read data, the tag, the requester ID and a lower-address field.

Requests longer than one dword are not forwarded to the bus. An oversized read is answered with a Completer Abort completion. An oversized write is discarded without any response. Only one request is handled at a time. The ready output to the receive side stays low from acceptance until the request is fully retired. A write is retired when the bus accepts it. A read is retired when the transmit side reports that its completion has been sent.

Top module: `pcie_sdw_completer`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_ready_o` is high, no bus command is asserted and `cpl_valid_o` is low. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. While a request is in progress, `req_ready_o` stays low.
- R2: An accepted read with length 1 drives `mm_read_o` from the cycle after acceptance until the first edge with `mm_wait_i` low. On the edge where `mm_rvalid_i` is high, `mm_rdata_i` is captured. `cpl_valid_o` rises in the next cycle with status 3'b000 (successful) and that data in `cpl_data_o`.
- R3: The bus address is formed as follows. Bits from WIN_BITS upward come from `win_base_i`, sampled at acceptance. Bits WIN_BITS-1 down to 2 come from the request address. Bits 1:0 are zero.
- R4: `mm_be_o` equals the request's first byte enables, unchanged, for both reads and writes. This holds for any pattern, including 4'b0000.
- R5: While a bus command is asserted and `mm_wait_i` is high, the command, address, byte enables and write data stay unchanged.
- R6: An accepted read with length other than 1 causes no bus access. `cpl_valid_o` rises in the next cycle with status 3'b100 (Completer Abort), data zero and the request's tag and requester ID.
- R7: An accepted write with length other than 1 causes no bus access and no completion. `req_ready_o` stays high.
- R8: An accepted write with length 1 drives `mm_write_o` with the request's data and never produces a completion. `req_ready_o` returns high in the cycle after the bus accepts the write (edge with `mm_wait_i` low).
- R9: While `cpl_valid_o` is high, all completion fields stay stable and `req_ready_o` stays low. On the edge where `cpl_sent_i` is high, the completion is retired: in the next cycle `cpl_valid_o` is low and `req_ready_o` is high.
- R10: `cpl_low_addr_o` has request address bits 6:2 in bits 6:2. Its bits 1:0 hold the index of the lowest set byte enable (bit 0 gives 0, bit 3 gives 3), or 0 when no byte enable is set. The completion also carries the original `req_tag_i` and `req_rid_i`.
- R11: The length field counts dwords. Only the value 1 is a single-dword request. The value 0 (which encodes 1024 dwords) and every value above 1 are oversized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request header and data valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_is_write_i | input | 1 | 1 = memory write, 0 = memory read |
| req_len_i | input | LEN_W | Length in dwords (0 encodes 1024) |
| req_addr_i | input | AW | Request byte address |
| req_be_i | input | DW/8 | First byte enables |
| req_tag_i | input | TAG_W | Request tag |
| req_rid_i | input | RID_W | Requester ID |
| req_wdata_i | input | DW | Write data |
| win_base_i | input | AW | Window base for address translation |
| mm_addr_o | output | AW | Master byte address |
| mm_read_o | output | 1 | Master read command |
| mm_write_o | output | 1 | Master write command |
| mm_be_o | output | DW/8 | Master byte enables |
| mm_wdata_o | output | DW | Master write data |
| mm_wait_i | input | 1 | Interconnect stalls the command |
| mm_rdata_i | input | DW | Read data |
| mm_rvalid_i | input | 1 | Read data valid |
| cpl_valid_o | output | 1 | Completion request to transmit side |
| cpl_status_o | output | 3 | Completion status (000 success, 100 abort) |
| cpl_tag_o | output | TAG_W | Tag of the completed request |
| cpl_rid_o | output | RID_W | Requester ID of the completed request |
| cpl_low_addr_o | output | 7 | Lower address field |
| cpl_data_o | output | DW | Completion data |
| cpl_sent_i | input | 1 | Transmit side has handed the completion to the link |

## Verification
The hardest state to reach is a read that spends time in every phase: the command stalled by waitrequest, then several cycles of read latency, then a completion held for many cycles before the sent acknowledgement. During all of that, the receive side must still see ready low. The bench sets the number of wait states, the read latency and the acknowledgement delay at random for each request. It also changes the request inputs right after acceptance, so any field that is not held in the block shows up as wrong. Directed cases cover length 0, length above 1, byte enables of zero and single-lane byte enables.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_RDWAIT,
    ST_CPL
  } sdw_state_e;

  localparam logic [2:0] CPL_SC = 3'b000;
  localparam logic [2:0] CPL_CA = 3'b100;
endpackage

// File: rtl/sdw_lower_addr.sv
module sdw_lower_addr #(
  parameter int BE_W = 4,
  localparam int OFS_W = $clog2(BE_W)
) (
  input  logic [6:OFS_W]   addr_hi_i,
  input  logic [BE_W-1:0]  be_i,
  output logic [6:0]       low_addr_o
);
  logic [OFS_W-1:0] ofs;

  // lowest set lane wins; empty mask maps to lane 0
  always_comb begin
    ofs = '0;
    for (int i = BE_W - 1; i >= 0; i--) begin
      if (be_i[i]) ofs = OFS_W'(i);
    end
  end

  assign low_addr_o = {addr_hi_i, ofs};
endmodule

// File: rtl/sdw_req_capture.sv
module sdw_req_capture
  import sdw_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int TAG_W    = 8,
  parameter int RID_W    = 16,
  parameter int WIN_BITS = 12,
  localparam int BE_W    = DW / 8,
  localparam int OFS_W   = $clog2(BE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             oversize_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [RID_W-1:0] rid_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    win_base_i,
  input  logic             rdata_load_i,
  input  logic [DW-1:0]    rdata_i,
  output logic [AW-1:0]    addr_o,
  output logic [BE_W-1:0]  be_o,
  output logic [DW-1:0]    wdata_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [RID_W-1:0] rid_o,
  output logic [6:0]       low_addr_o,
  output logic [2:0]       status_o,
  output logic [DW-1:0]    rdata_o
);
  localparam logic [AW-1:0] OFS_MASK  = (AW'(1) << WIN_BITS) - AW'(1);
  localparam logic [AW-1:0] LANE_MASK = AW'(BE_W - 1);

  logic [AW-1:0] xlat_addr;
  logic [6:0]    low_addr_d;

  assign xlat_addr = (win_base_i & ~OFS_MASK) | (addr_i & OFS_MASK & ~LANE_MASK);

  sdw_lower_addr #(.BE_W(BE_W)) i_low (
    .addr_hi_i  (addr_i[6:OFS_W]),
    .be_i       (be_i),
    .low_addr_o (low_addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      be_o       <= '0;
      wdata_o    <= '0;
      tag_o      <= '0;
      rid_o      <= '0;
      low_addr_o <= '0;
      status_o   <= CPL_SC;
    end else if (load_i) begin
      addr_o     <= xlat_addr;
      be_o       <= be_i;
      wdata_o    <= wdata_i;
      tag_o      <= tag_i;
      rid_o      <= rid_i;
      low_addr_o <= low_addr_d;
      status_o   <= oversize_i ? CPL_CA : CPL_SC;
    end
  end

  // cleared on accept so an abort completion returns zero data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdata_o <= '0;
    else if (load_i)       rdata_o <= '0;
    else if (rdata_load_i) rdata_o <= rdata_i;
  end
endmodule

// File: rtl/sdw_fsm.sv
module sdw_fsm
  import sdw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic is_write_i,
  input  logic oversize_i,
  input  logic mm_wait_i,
  input  logic mm_rvalid_i,
  input  logic cpl_sent_i,
  output logic ready_o,
  output logic load_o,
  output logic rdata_load_o,
  output logic mm_read_o,
  output logic mm_write_o,
  output logic cpl_valid_o
);
  sdw_state_e state_q, state_d;
  logic       wr_q;

  assign load_o = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (!oversize_i)     state_d = ST_BUS;
          else if (!is_write_i) state_d = ST_CPL;
        end
      end
      ST_BUS:    if (!mm_wait_i)  state_d = wr_q ? ST_IDLE : ST_RDWAIT;
      ST_RDWAIT: if (mm_rvalid_i) state_d = ST_CPL;
      ST_CPL:    if (cpl_sent_i)  state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) wr_q <= is_write_i;
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign mm_read_o    = (state_q == ST_BUS) && !wr_q;
  assign mm_write_o   = (state_q == ST_BUS) && wr_q;
  assign cpl_valid_o  = (state_q == ST_CPL);
  assign rdata_load_o = (state_q == ST_RDWAIT) && mm_rvalid_i;
endmodule

// File: rtl/pcie_sdw_completer.sv
module pcie_sdw_completer
  import sdw_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LEN_W    = 10,
  parameter int TAG_W    = 8,
  parameter int RID_W    = 16,
  parameter int WIN_BITS = 12,
  localparam int BE_W    = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_is_write_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [BE_W-1:0]  req_be_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [RID_W-1:0] req_rid_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [AW-1:0]    win_base_i,
  output logic [AW-1:0]    mm_addr_o,
  output logic             mm_read_o,
  output logic             mm_write_o,
  output logic [BE_W-1:0]  mm_be_o,
  output logic [DW-1:0]    mm_wdata_o,
  input  logic             mm_wait_i,
  input  logic [DW-1:0]    mm_rdata_i,
  input  logic             mm_rvalid_i,
  output logic             cpl_valid_o,
  output logic [2:0]       cpl_status_o,
  output logic [TAG_W-1:0] cpl_tag_o,
  output logic [RID_W-1:0] cpl_rid_o,
  output logic [6:0]       cpl_low_addr_o,
  output logic [DW-1:0]    cpl_data_o,
  input  logic             cpl_sent_i
);
  logic oversize;
  logic load;
  logic rdata_load;

  // length 1 only; 0 encodes 1024 dwords
  assign oversize = (req_len_i != LEN_W'(1));

  sdw_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .is_write_i   (req_is_write_i),
    .oversize_i   (oversize),
    .mm_wait_i    (mm_wait_i),
    .mm_rvalid_i  (mm_rvalid_i),
    .cpl_sent_i   (cpl_sent_i),
    .ready_o      (req_ready_o),
    .load_o       (load),
    .rdata_load_o (rdata_load),
    .mm_read_o    (mm_read_o),
    .mm_write_o   (mm_write_o),
    .cpl_valid_o  (cpl_valid_o)
  );

  sdw_req_capture #(
    .AW       (AW),
    .DW       (DW),
    .TAG_W    (TAG_W),
    .RID_W    (RID_W),
    .WIN_BITS (WIN_BITS)
  ) i_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .oversize_i   (oversize),
    .addr_i       (req_addr_i),
    .be_i         (req_be_i),
    .tag_i        (req_tag_i),
    .rid_i        (req_rid_i),
    .wdata_i      (req_wdata_i),
    .win_base_i   (win_base_i),
    .rdata_load_i (rdata_load),
    .rdata_i      (mm_rdata_i),
    .addr_o       (mm_addr_o),
    .be_o         (mm_be_o),
    .wdata_o      (mm_wdata_o),
    .tag_o        (cpl_tag_o),
    .rid_o        (cpl_rid_o),
    .low_addr_o   (cpl_low_addr_o),
    .status_o     (cpl_status_o),
    .rdata_o      (cpl_data_o)
  );
endmodule

// File: rtl/sdw_completer_chk.sv
module sdw_completer_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 10,
  parameter int TAG_W = 8,
  parameter int RID_W = 16,
  localparam int BE_W = DW / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_is_write_i,
  input logic [LEN_W-1:0] req_len_i,
  input logic [AW-1:0]    mm_addr_o,
  input logic             mm_read_o,
  input logic             mm_write_o,
  input logic [BE_W-1:0]  mm_be_o,
  input logic [DW-1:0]    mm_wdata_o,
  input logic             mm_wait_i,
  input logic [DW-1:0]    mm_rdata_i,
  input logic             mm_rvalid_i,
  input logic             cpl_valid_o,
  input logic [2:0]       cpl_status_o,
  input logic [TAG_W-1:0] cpl_tag_o,
  input logic [RID_W-1:0] cpl_rid_o,
  input logic [6:0]       cpl_low_addr_o,
  input logic [DW-1:0]    cpl_data_o,
  input logic             cpl_sent_i
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  p_busy_not_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_o || mm_write_o || cpl_valid_o) |-> !req_ready_o);

  p_one_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mm_read_o && mm_write_o) && !((mm_read_o || mm_write_o) && cpl_valid_o));

  p_single_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_len_i == LEN_W'(1)) |=> !req_ready_o && (mm_read_o || mm_write_o));

  p_rdata_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_rvalid_i && !req_ready_o && !mm_read_o && !mm_write_o && !cpl_valid_o) |=>
      cpl_valid_o && cpl_data_o == $past(mm_rdata_i) && cpl_status_o == 3'b000);

  p_addr_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_o || mm_write_o) |-> mm_addr_o[1:0] == 2'b00);

  p_hold_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mm_read_o || mm_write_o) && mm_wait_i) |=>
      $stable(mm_read_o) && $stable(mm_write_o) && $stable(mm_addr_o) &&
      $stable(mm_be_o) && $stable(mm_wdata_o));

  p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_is_write_i && req_len_i != LEN_W'(1)) |=>
      cpl_valid_o && cpl_status_o == 3'b100 && cpl_data_o == '0 && !mm_read_o);

  p_drop_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_is_write_i && req_len_i != LEN_W'(1)) |=>
      req_ready_o && !mm_write_o && !mm_read_o && !cpl_valid_o);

  p_posted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_write_o && !mm_wait_i) |=> req_ready_o && !cpl_valid_o);

  p_cpl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && !cpl_sent_i) |=>
      cpl_valid_o && !req_ready_o && $stable(cpl_status_o) && $stable(cpl_tag_o) &&
      $stable(cpl_rid_o) && $stable(cpl_low_addr_o) && $stable(cpl_data_o));

  p_cpl_retire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && cpl_sent_i) |=> !cpl_valid_o && req_ready_o);
endmodule

bind pcie_sdw_completer sdw_completer_chk #(
  .AW    (AW),
  .DW    (DW),
  .LEN_W (LEN_W),
  .TAG_W (TAG_W),
  .RID_W (RID_W)
) i_sdw_chk (.*);

// File: tb/test_pcie_sdw_completer.sv
`timescale 1ns/1ps
module test_pcie_sdw_completer;
  localparam int AW = 32, DW = 32, LEN_W = 10, TAG_W = 8, RID_W = 16, WIN_BITS = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_is_write = 0;
  logic [LEN_W-1:0] req_len = '0;
  logic [AW-1:0] req_addr = '0, win_base = '0, mm_addr;
  logic [3:0] req_be = '0, mm_be;
  logic [TAG_W-1:0] req_tag = '0, cpl_tag;
  logic [RID_W-1:0] req_rid = '0, cpl_rid;
  logic [DW-1:0] req_wdata = '0, mm_wdata, mm_rdata = '0, cpl_data;
  logic mm_read, mm_write, mm_wait = 0, mm_rvalid = 0, cpl_valid, cpl_sent = 0;
  logic [2:0] cpl_status;
  logic [6:0] cpl_low;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  pcie_sdw_completer #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .TAG_W(TAG_W),
                       .RID_W(RID_W), .WIN_BITS(WIN_BITS)) i_pcie_sdw_completer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_is_write_i(req_is_write), .req_len_i(req_len), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_tag_i(req_tag), .req_rid_i(req_rid), .req_wdata_i(req_wdata),
    .win_base_i(win_base), .mm_addr_o(mm_addr), .mm_read_o(mm_read), .mm_write_o(mm_write),
    .mm_be_o(mm_be), .mm_wdata_o(mm_wdata), .mm_wait_i(mm_wait), .mm_rdata_i(mm_rdata),
    .mm_rvalid_i(mm_rvalid), .cpl_valid_o(cpl_valid), .cpl_status_o(cpl_status),
    .cpl_tag_o(cpl_tag), .cpl_rid_o(cpl_rid), .cpl_low_addr_o(cpl_low),
    .cpl_data_o(cpl_data), .cpl_sent_i(cpl_sent));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [31:0] a);
    logic [31:0] m = (32'd1 << WIN_BITS) - 32'd1;
    return (base & ~m) | (a & m & ~32'd3);
  endfunction

  function automatic logic [6:0] exp_low(input logic [31:0] a, input logic [3:0] be);
    logic [1:0] o = 2'd0;
    if (be[0]) o = 2'd0; else if (be[1]) o = 2'd1; else if (be[2]) o = 2'd2; else if (be[3]) o = 2'd3;
    return {a[6:2], o};
  endfunction

  task automatic wait_sent(input int dly, input string rq);
    logic [DW-1:0] d = cpl_data;
    logic [2:0] s = cpl_status;
    logic [TAG_W-1:0] t = cpl_tag;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(cpl_valid && !req_ready, "R9 held/ready", {62'd0, cpl_valid, req_ready}, 64'h2);
      chk(cpl_data == d && cpl_status == s && cpl_tag == t, "R9 stable", 64'(cpl_data), 64'(d));
    end
    cpl_sent = 1;
    @(negedge clk);
    cpl_sent = 0;
    chk(!cpl_valid && req_ready, {rq, " R9 retire"}, {62'd0, cpl_valid, req_ready}, 64'h1);
  endtask

  task automatic do_req(input bit wr, input logic [LEN_W-1:0] len, input logic [31:0] a,
                        input logic [3:0] be, input logic [7:0] tag, input logic [15:0] rid,
                        input logic [31:0] wd, input logic [31:0] base,
                        input int nwait, input int lat, input int sdly);
    bit over = (len != 10'd1);
    logic [31:0] ea = exp_addr(base, a);
    logic [31:0] rd;
    @(negedge clk);
    chk(req_ready, "R1 ready idle", 64'(req_ready), 64'h1);
    req_valid = 1; req_is_write = wr; req_len = len; req_addr = a; req_be = be;
    req_tag = tag; req_rid = rid; req_wdata = wd; win_base = base;
    @(negedge clk);
    // scramble inputs: results must come from captured values
    req_valid = 0; req_addr = $urandom; req_be = 4'($urandom); req_tag = 8'($urandom);
    req_rid = 16'($urandom); req_wdata = $urandom; win_base = $urandom; req_len = 10'($urandom);
    if (over && wr) begin
      for (int i = 0; i < 2; i++) begin
        chk(req_ready && !mm_write && !mm_read && !cpl_valid, "R7 dropped write",
            {60'd0, req_ready, mm_write, mm_read, cpl_valid}, 64'h8);
        @(negedge clk);
      end
    end else if (over) begin
      chk(cpl_valid && !mm_read && !mm_write && !req_ready, "R6 abort cpl",
          {60'd0, cpl_valid, mm_read, mm_write, req_ready}, 64'h8);
      chk(cpl_status == 3'b100, (len == 0) ? "R11 len0 status" : "R6 status", 64'(cpl_status), 64'h4);
      chk(cpl_data == 0, "R6 data", 64'(cpl_data), 64'h0);
      chk(cpl_tag == tag && cpl_rid == rid, "R6 tag/rid", {40'd0, cpl_tag, cpl_rid}, {40'd0, tag, rid});
      wait_sent(sdly, "R6");
    end else begin
      chk(mm_read == !wr && mm_write == wr && !req_ready, "R2 cmd",
          {61'd0, mm_read, mm_write, req_ready}, {61'd0, !wr, wr, 1'b0});
      chk(mm_addr == ea, "R3 addr", 64'(mm_addr), 64'(ea));
      chk(mm_be == be, "R4 be", 64'(mm_be), 64'(be));
      if (wr) chk(mm_wdata == wd, "R8 wdata", 64'(mm_wdata), 64'(wd));
      for (int i = 0; i < nwait; i++) begin
        mm_wait = 1;
        @(negedge clk);
        chk(mm_read == !wr && mm_write == wr && mm_addr == ea && mm_be == be && !req_ready,
            "R5 hold", 64'(mm_addr), 64'(ea));
      end
      mm_wait = 0;
      @(negedge clk);
      if (wr) begin
        chk(req_ready && !mm_write && !cpl_valid, "R8 posted",
            {61'd0, req_ready, mm_write, cpl_valid}, 64'h4);
      end else begin
        chk(!mm_read && !cpl_valid && !req_ready, "R2 rd wait",
            {61'd0, mm_read, cpl_valid, req_ready}, 64'h0);
        for (int i = 1; i < lat; i++) @(negedge clk);
        rd = $urandom;
        mm_rvalid = 1; mm_rdata = rd;
        @(negedge clk);
        mm_rvalid = 0; mm_rdata = $urandom;
        chk(cpl_valid && cpl_status == 3'b000, "R2 cpl sc", {61'd0, cpl_status}, 64'h0);
        chk(cpl_data == rd, "R2 data", 64'(cpl_data), 64'(rd));
        chk(cpl_tag == tag && cpl_rid == rid, "R10 tag/rid", {40'd0, cpl_tag, cpl_rid}, {40'd0, tag, rid});
        chk(cpl_low == exp_low(a, be), "R10 low addr", 64'(cpl_low), 64'(exp_low(a, be)));
        wait_sent(sdly, "R2");
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mm_read && !mm_write && !cpl_valid, "R1 reset",
        {60'd0, req_ready, mm_read, mm_write, cpl_valid}, 64'h8);
    // directed
    do_req(0, 10'd1, 32'h0000_0A48, 4'hF, 8'h11, 16'h0100, 0, 32'hC000_0000, 0, 1, 0);
    do_req(0, 10'd1, 32'h1234_567C, 4'b0100, 8'h22, 16'h0200, 0, 32'h8000_5000, 3, 4, 5);
    do_req(0, 10'd1, 32'hFFFF_FFFF, 4'b0000, 8'h33, 16'h0300, 0, 32'h0000_0FFF, 1, 2, 1);
    do_req(0, 10'd1, 32'h0000_0044, 4'b1000, 8'h34, 16'h0301, 0, 32'h0, 0, 1, 2);
    do_req(1, 10'd1, 32'h0000_0F00, 4'b0011, 8'h44, 16'h0400, 32'hDEAD_BEEF, 32'hA000_0000, 2, 1, 0);
    do_req(1, 10'd1, 32'h0000_0104, 4'hF, 8'h45, 16'h0401, 32'h0BAD_F00D, 32'h1000_0000, 0, 1, 0);
    do_req(0, 10'd2, 32'h0000_0010, 4'hF, 8'h55, 16'h0500, 0, 32'h0, 0, 1, 3);
    do_req(0, 10'd0, 32'h0000_0020, 4'hF, 8'h66, 16'h0600, 0, 32'h0, 0, 1, 0);
    do_req(1, 10'd5, 32'h0000_0030, 4'hF, 8'h77, 16'h0700, 32'h1, 32'h0, 0, 1, 0);
    do_req(1, 10'd0, 32'h0000_0034, 4'hF, 8'h78, 16'h0701, 32'h2, 32'h0, 0, 1, 0);
    // random mix
    for (int k = 0; k < 80; k++) begin
      logic [LEN_W-1:0] l = ($urandom_range(0, 9) < 7) ? 10'd1 : 10'($urandom);
      do_req(1'($urandom), l, $urandom, 4'($urandom), 8'($urandom), 16'($urandom),
             $urandom, $urandom, $urandom_range(0, 4), $urandom_range(1, 5), $urandom_range(0, 6));
    end
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule